// File: doc/BRIEF.md
# Four-Channel Block-Mode DMA Controller

This block moves bytes between peripherals and memory, or from one memory region to another, without the processor touching each byte. Each of four channels holds a 16-bit current address and a 16-bit current count. A peripheral raises its request line. The controller then asks the processor for the system bus with a hold request. Once hold acknowledge arrives, it owns the bus and runs a block of byte cycles. Each cycle drives an address and a pair of read/write strobes.

While the controller is idle, the processor programs it through a small register port. That port uses an active-low chip select with active-low I/O read and I/O write strobes. During a transfer, the low address byte leaves on a dedicated bus and the high byte leaves on the data lines, so that an external latch can capture it. A transfer ends when the count wraps below zero or when the end-of-process input is pulled low. The controller then hands the bus back to the processor.

Top module: `dma4_ctrl`

## Requirements
- R1: After reset, `hrq`, `aen`, `tc` and `xfer_end` are low, every `dack_n` bit is high, and all current addresses and counts read zero.
- R2: A register write happens on a clock where `cs_n` and `iow_n` are both low and the controller does not own the bus. `reg_addr` bit 4 set selects the control byte. Otherwise bits 3:2 pick the channel, bit 1 picks the field (0 address, 1 count) and bit 0 picks the byte (0 low, 1 high). A read with `cs_n` and `ior_n` low puts that byte on `dout` one clock later. Channel reads return the current values.
- R3: With the control byte's bit 0 set and an eligible request present, `hrq` rises. No strobe, acknowledge or `aen` appears until `hlda` is high.
- R4: Pending requests are ranked by fixed priority, with channel 0 highest. The winner is latched at grant and keeps the bus for its whole block, even if a higher-priority request arrives meanwhile.
- R5: Byte k of a block uses address start+k, modulo 2^16. Bits 7:0 appear on `addr_lo` and bits 15:8 on `dout` during the strobe cycle.
- R6: A programmed count N moves N+1 bytes. `tc` is high exactly in the strobe cycle of the last byte. Afterwards the current count reads N-(N+1) modulo 2^16, which is all ones.
- R7: If `eop_n` is low at the end of a strobe cycle, that byte is the last one of the block.
- R8: Each channel has a direction bit at control bit 2+channel. With the bit set, the strobe cycle drives `io_rd_n` and `mem_wr_n` low (device to memory). With it clear, it drives `mem_rd_n` and `io_wr_n` low.
- R9: With control bit 1 set, request 0 starts a memory copy. Each byte is a `mem_rd_n` cycle at channel 0's address followed by a `mem_wr_n` cycle at channel 1's address. Channel 0's count governs the length, no `dack_n` is asserted, and `tc` marks the last write.
- R10: At the end of a block, `xfer_end` pulses for one clock. In that clock `hrq` and `aen` are already low, and the bus outputs go to high impedance.
- R11: A channel that has finished its block does not request the bus again until its count is rewritten. With control bit 0 clear, no request raises `hrq`.
- R12: While the controller owns the bus for a device transfer, only the latched channel's `dack_n` is low. No `dack_n` is low when the controller does not own the bus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dreq | input | 4 | Per-channel transfer request, active high |
| dack_n | output | 4 | Per-channel acknowledge, active low |
| hrq | output | 1 | Bus hold request to the processor |
| hlda | input | 1 | Hold acknowledge from the processor |
| cs_n | input | 1 | Register port select, active low |
| ior_n | input | 1 | Register read strobe, active low |
| iow_n | input | 1 | Register write strobe, active low |
| reg_addr | input | 5 | Register select |
| din | input | 8 | Register write data |
| dout | output | 8 | Read data in slave mode, high address byte in master mode, otherwise high impedance |
| addr_lo | output | 8 | Low address byte while owning the bus |
| mem_rd_n | output | 1 | Memory read strobe |
| mem_wr_n | output | 1 | Memory write strobe |
| io_rd_n | output | 1 | Device read strobe |
| io_wr_n | output | 1 | Device write strobe |
| aen | output | 1 | High while the controller owns the bus |
| tc | output | 1 | Terminal count pulse on the last byte |
| xfer_end | output | 1 | One-clock pulse when a block ends |
| eop_n | input | 1 | External end-of-process, active low |

## Verification
The hardest state to reach from the ports is a higher-priority request that arrives while a lower channel already holds the bus. The stimulus programs three channels, raises two requests together, and raises channel 0's request only at the first strobe of the channel-1 block. The acknowledge sequence must then read channel 1, channel 1, channel 0, channel 3, channel 3. Early termination is produced by pulling `eop_n` low in exactly the strobe cycle of a chosen byte, including byte 0. Address wrap is produced by starting a block at 0xFFFE.

// File: rtl/dma4_pkg.sv
package dma4_pkg;
  typedef enum logic [2:0] {
    S_IDLE, S_HOLD, S_T1, S_T2, S_T3, S_T4, S_END
  } dma_state_t;
endpackage

// File: rtl/dma4_prio.sv
module dma4_prio #(
  parameter int NCH = 4,
  parameter int CHW = 2
) (
  input  logic [NCH-1:0] req,
  output logic           any,
  output logic [CHW-1:0] idx
);
  always_comb begin
    any = |req;
    idx = '0;
    for (int i = NCH - 1; i >= 0; i--) begin
      if (req[i]) idx = CHW'(i);
    end
  end
endmodule

// File: rtl/dma4_chan.sv
module dma4_chan #(
  parameter int AW = 16,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic          field,
  input  logic          hi,
  input  logic [7:0]    wdata,
  input  logic          inc_addr,
  input  logic          dec_cnt,
  input  logic          set_done,
  output logic [AW-1:0] cur_addr,
  output logic [CW-1:0] cur_cnt,
  output logic          done
);
  always_ff @(posedge clk) begin
    if (rst) begin
      cur_addr <= '0;
      cur_cnt  <= '0;
      done     <= 1'b0;
    end else if (we) begin
      if (!field) begin
        if (hi) cur_addr[AW-1:8] <= wdata[AW-9:0];
        else    cur_addr[7:0]    <= wdata;
      end else begin
        if (hi) cur_cnt[CW-1:8] <= wdata[CW-9:0];
        else    cur_cnt[7:0]    <= wdata;
        done <= 1'b0;
      end
    end else begin
      if (inc_addr) cur_addr <= cur_addr + 1'b1;
      if (dec_cnt)  cur_cnt  <= cur_cnt - 1'b1;
      if (set_done) done     <= 1'b1;
    end
  end
endmodule

// File: rtl/dma4_ctrl.sv
module dma4_ctrl
  import dma4_pkg::*;
#(
  parameter int NCH = 4,
  parameter int AW  = 16,
  parameter int CW  = 16,
  localparam int CHW = $clog2(NCH),
  localparam int RAW = CHW + 3
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [NCH-1:0] dreq,
  output logic [NCH-1:0] dack_n,
  output logic           hrq,
  input  logic           hlda,
  input  logic           cs_n,
  input  logic           ior_n,
  input  logic           iow_n,
  input  logic [RAW-1:0] reg_addr,
  input  logic [7:0]     din,
  output logic [7:0]     dout,
  output logic [7:0]     addr_lo,
  output logic           mem_rd_n,
  output logic           mem_wr_n,
  output logic           io_rd_n,
  output logic           io_wr_n,
  output logic           aen,
  output logic           tc,
  output logic           xfer_end,
  input  logic           eop_n
);
  dma_state_t     state;
  logic [CHW-1:0] sel;
  logic           ctrl_en, ctrl_m2m;
  logic [NCH-1:0] ctrl_dir;
  logic [AW-1:0]  ca [NCH];
  logic [CW-1:0]  cc [NCH];
  logic [NCH-1:0] done;
  logic [NCH-1:0] elig;
  logic           any;
  logic [CHW-1:0] idx;
  logic           own, strb_a, strb_b, step, last, stop, reg_we;
  logic [15:0]    xa;
  logic [15:0]    rword;
  logic [7:0]     rdq;
  logic [CHW-1:0] rch;

  assign own    = (state == S_T1) || (state == S_T2) || (state == S_T3) || (state == S_T4);
  assign strb_a = (state == S_T2);
  assign strb_b = (state == S_T4);
  assign step   = (strb_a && !ctrl_m2m) || strb_b;
  assign last   = (cc[sel] == '0);
  assign stop   = last || !eop_n;
  assign reg_we = !cs_n && !iow_n && !own;
  assign rch    = reg_addr[RAW-2:2];

  always_comb begin
    if (!ctrl_en)      elig = '0;
    else if (ctrl_m2m) elig = {{(NCH-1){1'b0}}, dreq[0] & ~done[0]};
    else               elig = dreq & ~done;
  end

  dma4_prio #(.NCH(NCH), .CHW(CHW)) u_prio (.req(elig), .any(any), .idx(idx));

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    dma4_chan #(.AW(AW), .CW(CW)) u_chan (
      .clk      (clk),
      .rst      (rst),
      .we       (reg_we && !reg_addr[RAW-1] && (rch == CHW'(g))),
      .field    (reg_addr[1]),
      .hi       (reg_addr[0]),
      .wdata    (din),
      .inc_addr (step && ((sel == CHW'(g)) || (ctrl_m2m && (g == 1)))),
      .dec_cnt  (step && (sel == CHW'(g))),
      .set_done (step && stop && (sel == CHW'(g))),
      .cur_addr (ca[g]),
      .cur_cnt  (cc[g]),
      .done     (done[g])
    );
    assign dack_n[g] = !(own && !ctrl_m2m && (sel == CHW'(g)));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= S_IDLE;
      sel   <= '0;
    end else begin
      case (state)
        S_IDLE: if (ctrl_en && any) state <= S_HOLD;
        S_HOLD: begin
          if (!any) state <= S_IDLE;
          else if (hlda) begin
            sel   <= idx;
            state <= S_T1;
          end
        end
        S_T1:   state <= S_T2;
        S_T2:   state <= ctrl_m2m ? S_T3 : (stop ? S_END : S_T1);
        S_T3:   state <= S_T4;
        S_T4:   state <= stop ? S_END : S_T1;
        default: state <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_en  <= 1'b0;
      ctrl_m2m <= 1'b0;
      ctrl_dir <= '0;
    end else if (reg_we && reg_addr[RAW-1]) begin
      ctrl_en  <= din[0];
      ctrl_m2m <= din[1];
      ctrl_dir <= din[2 +: NCH];
    end
  end

  assign rword = reg_addr[1] ? 16'(cc[rch]) : 16'(ca[rch]);

  always_ff @(posedge clk) begin
    if (rst) rdq <= '0;
    else if (reg_addr[RAW-1]) rdq <= 8'({ctrl_dir, ctrl_m2m, ctrl_en});
    else rdq <= reg_addr[0] ? rword[15:8] : rword[7:0];
  end

  assign xa = (ctrl_m2m && (state == S_T3 || state == S_T4)) ? 16'(ca[1]) : 16'(ca[sel]);

  assign addr_lo  = own ? xa[7:0] : 'z;
  assign dout     = own ? xa[15:8] : ((!cs_n && !ior_n) ? rdq : 'z);
  assign mem_rd_n = own ? !(strb_a && (ctrl_m2m || !ctrl_dir[sel])) : 1'bz;
  assign mem_wr_n = own ? !((strb_a && !ctrl_m2m && ctrl_dir[sel]) || strb_b) : 1'bz;
  assign io_rd_n  = own ? !(strb_a && !ctrl_m2m && ctrl_dir[sel]) : 1'bz;
  assign io_wr_n  = own ? !(strb_a && !ctrl_m2m && !ctrl_dir[sel]) : 1'bz;
  assign aen      = own;
  assign hrq      = (state != S_IDLE) && (state != S_END);
  assign tc       = step && last;
  assign xfer_end = (state == S_END);
endmodule

// File: rtl/dma4_ctrl_chk.sv
module dma4_ctrl_chk #(
  parameter int NCH = 4
) (
  input logic           clk,
  input logic           rst,
  input logic [NCH-1:0] dack_n,
  input logic           hrq,
  input logic           hlda,
  input logic           aen,
  input logic           tc,
  input logic           xfer_end,
  input logic           mem_rd_n,
  input logic           mem_wr_n,
  input logic           io_wr_n
);
  a_r3_own_needs_grant: assert property (@(posedge clk) disable iff (rst)
    aen |-> (hrq && hlda));
  a_r12_single_ack: assert property (@(posedge clk) disable iff (rst)
    $onehot0(~dack_n));
  a_r12_ack_only_owned: assert property (@(posedge clk) disable iff (rst)
    (dack_n != {NCH{1'b1}}) |-> aen);
  a_r6_tc_on_write_strobe: assert property (@(posedge clk) disable iff (rst)
    tc |-> (aen && (!mem_wr_n || !io_wr_n)));
  a_r10_end_released: assert property (@(posedge clk) disable iff (rst)
    xfer_end |-> (!aen && !hrq));
  a_r10_end_single: assert property (@(posedge clk) disable iff (rst)
    xfer_end |=> !xfer_end);
  a_r9_no_mem_overlap: assert property (@(posedge clk) disable iff (rst)
    aen |-> !(!mem_rd_n && !mem_wr_n));
endmodule

bind dma4_ctrl dma4_ctrl_chk #(.NCH(NCH)) u_chk (
  .clk(clk), .rst(rst), .dack_n(dack_n), .hrq(hrq), .hlda(hlda), .aen(aen),
  .tc(tc), .xfer_end(xfer_end), .mem_rd_n(mem_rd_n), .mem_wr_n(mem_wr_n),
  .io_wr_n(io_wr_n)
);

// File: tb/dma4_ctrl_test.sv
module dma4_ctrl_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] dreq = '0;
  logic [3:0] dack_n;
  logic       hrq, hlda = 1'b0;
  logic       cs_n = 1'b1, ior_n = 1'b1, iow_n = 1'b1;
  logic [4:0] reg_addr = '0;
  logic [7:0] din = '0;
  logic [7:0] dout, addr_lo;
  logic       mem_rd_n, mem_wr_n, io_rd_n, io_wr_n;
  logic       aen, tc, xfer_end;
  logic       eop_n = 1'b1;
  int         errors = 0, checks = 0, hlda_delay = 1;
  bit         finished = 0;

  always #4 clk = ~clk;

  dma4_ctrl uut (
    .clk(clk), .rst(rst), .dreq(dreq), .dack_n(dack_n), .hrq(hrq), .hlda(hlda),
    .cs_n(cs_n), .ior_n(ior_n), .iow_n(iow_n), .reg_addr(reg_addr), .din(din),
    .dout(dout), .addr_lo(addr_lo), .mem_rd_n(mem_rd_n), .mem_wr_n(mem_wr_n),
    .io_rd_n(io_rd_n), .io_wr_n(io_wr_n), .aen(aen), .tc(tc),
    .xfer_end(xfer_end), .eop_n(eop_n)
  );

  initial begin
    int lat = 0;
    forever begin
      @(negedge clk);
      if (!hrq) begin hlda = 1'b0; lat = 0; end
      else if (!hlda) begin
        lat++;
        if (lat >= hlda_delay) hlda = 1'b1;
      end
    end
  end

  task automatic chk(input bit ok, input string r, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", r, what, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk);
    cs_n = 0; iow_n = 0; reg_addr = 5'(a); din = 8'(d);
    @(negedge clk);
    cs_n = 1; iow_n = 1;
  endtask

  task automatic rd(input int a, output logic [7:0] d);
    @(negedge clk);
    cs_n = 0; ior_n = 0; reg_addr = 5'(a);
    @(negedge clk);
    d = dout;
    cs_n = 1; ior_n = 1;
  endtask

  task automatic prog(input int ch, input int a, input int c);
    wr(ch*4+0, a & 255); wr(ch*4+1, (a >> 8) & 255);
    wr(ch*4+2, c & 255); wr(ch*4+3, (c >> 8) & 255);
  endtask

  task automatic run(input int ch, input int base, input int cnt, input int dir, input int eop_at);
    int k = 0;
    int n;
    logic [15:0] a;
    logic [7:0] lo, hi;
    bit sa, sb;
    prog(ch, base, cnt);
    wr(16, 1 | (dir << (2 + ch)));
    dreq[ch] = 1'b1;
    forever begin
      @(negedge clk);
      if (hrq && !hlda) chk(aen == 0, "R3", "bus taken before grant", aen, 0);
      if (xfer_end) break;
      sa = dir ? (io_rd_n == 0) : (mem_rd_n == 0);
      if (aen && sa) begin
        a = {dout, addr_lo};
        chk(a == 16'(base + k), "R5", "byte address", a, 16'(base + k));
        sb = dir ? (mem_wr_n == 0) : (io_wr_n == 0);
        chk(sb, "R8", "paired strobe", sb, 1);
        chk(dack_n == ~(4'b1 << ch), "R12", "acknowledge", dack_n, 4'hF & ~(4'b1 << ch));
        chk(tc == (k == cnt), "R6", "terminal count", tc, k == cnt);
        eop_n = (k == eop_at) ? 1'b0 : 1'b1;
        k++;
      end else eop_n = 1'b1;
    end
    eop_n = 1'b1;
    n = (eop_at >= 0 && eop_at < cnt) ? eop_at + 1 : cnt + 1;
    chk(k == n, (eop_at >= 0) ? "R7" : "R6", "bytes moved", k, n);
    chk(!hrq && !aen, "R10", "bus released at end", {hrq, aen}, 0);
    repeat (8) @(negedge clk);
    chk(hrq == 0, "R11", "finished channel stays quiet", hrq, 0);
    dreq[ch] = 1'b0;
    rd(ch*4+0, lo); rd(ch*4+1, hi);
    chk({hi, lo} == 16'(base + n), "R2", "current address readback", {hi, lo}, 16'(base + n));
    rd(ch*4+2, lo); rd(ch*4+3, hi);
    chk({hi, lo} == 16'(cnt - n), "R6", "current count readback", {hi, lo}, 16'(cnt - n));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    int ends, s, r, w;
    logic [3:0] exp_ack;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(!hrq && !aen && !tc && !xfer_end, "R1", "reset outputs", {hrq, aen, tc, xfer_end}, 0);
    chk(dack_n == 4'hF, "R1", "reset acknowledge", dack_n, 4'hF);
    rd(2, v);
    chk(v == 0, "R1", "reset count", v, 0);

    wr(16, 8'h34);
    rd(16, v);
    chk(v == 8'h34, "R2", "control readback", v, 8'h34);
    wr(16, 0);

    for (int ch = 0; ch < 4; ch++)
      for (int cnt = 0; cnt < 4; cnt++)
        for (int dir = 0; dir < 2; dir++) begin
          hlda_delay = 1 + (ch + cnt + dir) % 3;
          run(ch, 16'h1000 * (ch + 1) + cnt * 16 + dir, cnt, dir, -1);
        end

    run(2, 16'hFFFE, 3, 1, -1);
    run(1, 16'h0100, 9, 0, 3);
    run(3, 16'h0A00, 5, 1, 0);

    prog(2, 16'h0050, 0);
    wr(16, 0);
    dreq = 4'b0100;
    repeat (10) @(negedge clk);
    chk(hrq == 0, "R11", "disabled controller ignores request", hrq, 0);
    dreq = '0;

    prog(1, 16'h0200, 1); prog(3, 16'h0300, 1); prog(0, 16'h0100, 0);
    wr(16, 1);
    dreq = 4'b1010;
    ends = 0; s = 0;
    while (ends < 3) begin
      @(negedge clk);
      if (xfer_end) ends++;
      else if (aen && mem_rd_n == 0) begin
        exp_ack = (s < 2) ? 4'b1101 : ((s == 2) ? 4'b1110 : 4'b0111);
        chk(dack_n == exp_ack, "R4", "priority order", dack_n, exp_ack);
        if (s == 0) dreq[0] = 1'b1;
        s++;
      end
    end
    chk(s == 5, "R4", "total priority bytes", s, 5);
    dreq = '0;

    prog(0, 16'h3000, 2); prog(1, 16'h4000, 9);
    wr(16, 3);
    dreq[0] = 1'b1;
    r = 0; w = 0;
    forever begin
      @(negedge clk);
      if (xfer_end) break;
      if (aen) begin
        chk(io_rd_n == 1 && io_wr_n == 1 && dack_n == 4'hF, "R9", "no device signals", dack_n, 4'hF);
        if (mem_rd_n == 0) begin
          chk({dout, addr_lo} == 16'(16'h3000 + r), "R9", "copy source", {dout, addr_lo}, 16'h3000 + r);
          r++;
        end
        if (mem_wr_n == 0) begin
          chk({dout, addr_lo} == 16'(16'h4000 + w), "R9", "copy destination", {dout, addr_lo}, 16'h4000 + w);
          chk(tc == (w == 2), "R9", "copy terminal count", tc, w == 2);
          w++;
        end
      end
    end
    chk(r == 3 && w == 3, "R9", "copy length", r * 16 + w, 8'h33);
    dreq = '0;
    wr(16, 0);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule